// File: doc/BRIEF.md
# GPIO Per-Pin Interrupt and Wake Detector

This block watches the synchronized input levels of a 32-pin port and decides, pin by pin, when an interrupt condition has occurred. Each pin is set to level or edge sensing, with an active polarity. In edge sensing a dual-edge bit makes both transitions count and overrides the polarity. A pin whose interrupt enable is set latches its condition into a pending flag. The flag stays set until software writes a one to that pin's bit on the clear-mask port.

The pending flags are brought out as a vector for software to read. The block also drives one interrupt request, which is the OR of all pending flags. A separate wake request is raised directly from each pin's trigger condition when that pin's wake enable is set. It does not depend on the flags. Register decoding and pad electrical behaviour are handled elsewhere. Edges are found by comparing each sample with the one taken the cycle before.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and right after it is released, every pending flag, `irq_req` and `wake_req` are 0.
- R2: A pin with mode bit 0 (level) and polarity bit 1 whose input is high at a clock edge, with its interrupt enable at 1, has its pending flag at 1 after that edge.
- R3: A pin with mode bit 0 and polarity bit 0 whose input is low at a clock edge, with its interrupt enable at 1, has its pending flag at 1 after that edge.
- R4: With mode bit 1 (edge) and dual-edge bit 0, a pin with polarity 1 sets its flag only on a 0-to-1 change between consecutive samples, and a pin with polarity 0 only on a 1-to-0 change. A steady input sets nothing.
- R5: With mode bit 1 and dual-edge bit 1, both rising and falling changes set the flag, whatever the polarity bit is.
- R6: In level mode the dual-edge bit has no effect: an input at the inactive level sets no flag.
- R7: A pin whose interrupt enable is 0 never sets its pending flag.
- R8: For each bit at 1 on `flag_clr` in a cycle, that pending flag is 0 after the clock edge, unless it is set again in that cycle. Flags whose `flag_clr` bit is 0 keep their value.
- R9: In level mode, if the active level is still present when a clear is applied, the flag reads 1 again after that edge.
- R10: If a new edge trigger and a clear hit the same bit in the same cycle, the flag is 1 after the edge (set wins).
- R11: `irq_req` is 1 exactly when at least one pending flag is 1. An edge-set flag stays pending after the input returns to its idle level.
- R12: `wake_req` is the OR over pins of (wake enable AND the pin's current trigger condition). It does not depend on interrupt enables or flags, and it is 0 when all wake enables are 0.
- R13: No edge is reported on the first clock edge after reset is released, because no earlier sample exists yet. An input held high through reset causes no rising-edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin input levels |
| trig_mode | input | 32 | Per pin: 0 level, 1 edge |
| trig_pol | input | 32 | Per pin: 1 rising/high, 0 falling/low |
| dual_edge | input | 32 | Per pin: 1 selects both edges in edge mode |
| irq_en | input | 32 | Per pin interrupt enable |
| wake_en | input | 32 | Per pin wake enable |
| flag_clr | input | 32 | Write-one-to-clear mask for pending flags, one-cycle strobe |
| pend_flags | output | 32 | Pending interrupt flags, 1 = pending |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake request |

## Verification
The properties assume that `pin_lvl` has already been synchronized to `clk`. They also assume that `flag_clr` and the control vectors change only between clock edges, so every edge sees one stable value of each. The bench drives all inputs on the falling clock edge and holds `flag_clr` for exactly one cycle, so every sample is well defined. The properties further assume that nothing outside the pending-flag logic touches the flags. Edges are created only by changing `pin_lvl` after at least one settled sample, which keeps each detection tied to a single input change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  localparam int unsigned DEF_PINS = 32;
endpackage

// File: rtl/gpio_irq_sampler.sv
// Keeps the previous-cycle sample of every pin and reports rising and falling
// changes. Edge reports stay quiet until one sample has been taken after reset.
module gpio_irq_sampler #(
  parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] lvl,
  output logic [PINS-1:0] rise,
  output logic [PINS-1:0] fall
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] prev_d;
  logic            primed_q;
  logic            primed_d;
  logic            primed_en;

  always_comb begin
    prev_d    = lvl;
    primed_d  = 1'b1;
    primed_en = ~primed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (primed_en) primed_q <= primed_d;
    end
  end

  always_comb begin
    rise = primed_q ? (lvl & ~prev_q) : '0;
    fall = primed_q ? (~lvl & prev_q) : '0;
  end
endmodule

// File: rtl/gpio_irq_trigger.sv
// Per-pin trigger selection: level match or chosen edge(s).
module gpio_irq_trigger #(
  parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] rise,
  input  logic [PINS-1:0] fall,
  input  logic [PINS-1:0] mode,
  input  logic [PINS-1:0] pol,
  input  logic [PINS-1:0] dual,
  output logic [PINS-1:0] trig
);
  import gpio_irq_pkg::*;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    sense_e sense;
    assign sense = sense_e'(mode[g]);

    always_comb begin
      if (sense == SENSE_EDGE) begin
        if (dual[g]) trig[g] = rise[g] | fall[g];
        else         trig[g] = pol[g] ? rise[g] : fall[g];
      end else begin
        trig[g] = ~(lvl[g] ^ pol[g]);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_flags.sv
// Pending-flag bank: sticky set from enabled triggers, write-one-to-clear,
// set has priority over clear on the same bit.
module gpio_irq_flags #(
  parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] set_vec,
  input  logic [PINS-1:0] clr_vec,
  output logic [PINS-1:0] flags
);
  logic [PINS-1:0] flags_q;
  logic [PINS-1:0] flags_d;
  logic            flags_en;

  always_comb begin
    flags_d  = (flags_q & ~clr_vec) | set_vec;
    flags_en = |(set_vec | clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_lvl,
  input  logic [PINS-1:0] trig_mode,
  input  logic [PINS-1:0] trig_pol,
  input  logic [PINS-1:0] dual_edge,
  input  logic [PINS-1:0] irq_en,
  input  logic [PINS-1:0] wake_en,
  input  logic [PINS-1:0] flag_clr,
  output logic [PINS-1:0] pend_flags,
  output logic            irq_req,
  output logic            wake_req
);
  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;
  logic [PINS-1:0] trig;
  logic [PINS-1:0] set_vec;

  gpio_irq_sampler #(.PINS(PINS)) u_sampler (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pin_lvl),
    .rise (rise),
    .fall (fall)
  );

  gpio_irq_trigger #(.PINS(PINS)) u_trigger (
    .lvl (pin_lvl),
    .rise(rise),
    .fall(fall),
    .mode(trig_mode),
    .pol (trig_pol),
    .dual(dual_edge),
    .trig(trig)
  );

  assign set_vec = trig & irq_en;

  gpio_irq_flags #(.PINS(PINS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(flag_clr),
    .flags  (pend_flags)
  );

  assign irq_req  = |pend_flags;
  assign wake_req = |(trig & wake_en);
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pin_lvl,
  input logic [PINS-1:0] trig_mode,
  input logic [PINS-1:0] trig_pol,
  input logic [PINS-1:0] irq_en,
  input logic [PINS-1:0] wake_en,
  input logic [PINS-1:0] flag_clr,
  input logic [PINS-1:0] pend_flags,
  input logic            irq_req,
  input logic            wake_req
);
  logic [PINS-1:0] lvl_hit;
  assign lvl_hit = ~trig_mode & ~(pin_lvl ^ trig_pol) & irq_en;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (pend_flags == '0) && !irq_req);

  assert_level_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((pend_flags & $past(lvl_hit)) == $past(lvl_hit)));

  assert_disabled_never_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_flags & ~$past(pend_flags) & ~$past(irq_en)) == '0));

  assert_uncleared_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_flags) & ~$past(flag_clr) & ~pend_flags) == '0));

  assert_clear_effective_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & ~irq_en) != '0) |=> ((pend_flags & $past(flag_clr & ~irq_en)) == '0));

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(irq_en) != '0));

  assert_wake_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en == '0) |-> !wake_req);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.PINS(PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_lvl   (pin_lvl),
  .trig_mode (trig_mode),
  .trig_pol  (trig_pol),
  .irq_en    (irq_en),
  .wake_en   (wake_en),
  .flag_clr  (flag_clr),
  .pend_flags(pend_flags),
  .irq_req   (irq_req),
  .wake_req  (wake_req)
);

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;
  localparam int unsigned N = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_lvl, trig_mode, trig_pol, dual_edge, irq_en, wake_en, flag_clr;
  logic [N-1:0] pend_flags;
  logic         irq_req, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.PINS(N)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_mode(trig_mode),
    .trig_pol(trig_pol), .dual_edge(dual_edge), .irq_en(irq_en),
    .wake_en(wake_en), .flag_clr(flag_clr), .pend_flags(pend_flags),
    .irq_req(irq_req), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [N-1:0] lvl_in_reset);
    rst_n     = 1'b0;
    pin_lvl   = lvl_in_reset;
    trig_mode = '0; trig_pol = '0; dual_edge = '0;
    irq_en    = '0; wake_en  = '0; flag_clr  = '0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset('0);
    #1;
    chk("R1 flags", pend_flags, '0);
    chk("R1 irq", {31'd0, irq_req}, '0);
    chk("R1 wake", {31'd0, wake_req}, '0);
  endtask

  task automatic t_first_sample();
    do_reset('1);
    trig_mode = '1; trig_pol = '1; irq_en = '1;
    tick(); tick(); tick();
    chk("R13 no edge after reset", pend_flags, '0);
  endtask

  task automatic t_level();
    do_reset('0);
    trig_pol = 32'h1; irq_en = 32'h3;
    pin_lvl  = 32'h1;
    tick();
    chk("R2 R3 level high/low", pend_flags, 32'h3);
    chk("R11 irq on", {31'd0, irq_req}, 32'h1);
    irq_en = 32'h0; flag_clr = 32'h3;
    tick(); flag_clr = '0;
    chk("R8 cleared", pend_flags, '0);
    chk("R11 irq off", {31'd0, irq_req}, '0);
  endtask

  task automatic t_edge_single();
    do_reset('0);
    trig_mode = 32'h18; trig_pol = 32'h08; irq_en = 32'h18;
    pin_lvl = 32'h10; tick();
    chk("R4 steady/rise on falling pin", pend_flags, '0);
    pin_lvl = 32'h08; tick();
    chk("R4 rise and fall", pend_flags, 32'h18);
    flag_clr = 32'h18; tick(); flag_clr = '0;
    tick();
    chk("R4 steady level no set", pend_flags, '0);
    pin_lvl = 32'h00; tick();
    chk("R4 wrong edges ignored", pend_flags, 32'h00);
    pin_lvl = 32'h08; tick(); pin_lvl = '0; tick(); tick();
    chk("R11 edge flag latched", pend_flags, 32'h08);
  endtask

  task automatic t_dual();
    do_reset('0);
    trig_mode = 32'h20; dual_edge = 32'h20; irq_en = 32'h20;
    tick();
    pin_lvl = 32'h20; tick();
    chk("R5 dual rise", pend_flags, 32'h20);
    flag_clr = 32'h20; tick(); flag_clr = '0;
    chk("R5 cleared", pend_flags, '0);
    pin_lvl = '0; tick();
    chk("R5 dual fall polarity ignored", pend_flags, 32'h20);
  endtask

  task automatic t_dual_level();
    do_reset('0);
    dual_edge = 32'h40; trig_pol = 32'h40; irq_en = 32'h40;
    tick(); pin_lvl = 32'h40; tick(); pin_lvl = '0; tick();
    flag_clr = 32'h40; tick(); flag_clr = '0; tick();
    chk("R6 dual ignored in level mode", pend_flags, '0);
  endtask

  task automatic t_disabled_and_wake();
    do_reset('0);
    trig_pol = 32'h80; pin_lvl = 32'h80; wake_en = 32'h80;
    #1;
    chk("R12 wake from level w/o irq enable", {31'd0, wake_req}, 32'h1);
    tick(); tick();
    chk("R7 disabled no flag", pend_flags, '0);
    wake_en = '0; #1;
    chk("R12 wake gated", {31'd0, wake_req}, '0);
    trig_mode = 32'h80; pin_lvl = '0; tick();
    pin_lvl = 32'h80; wake_en = 32'h80; #1;
    chk("R12 wake on edge", {31'd0, wake_req}, 32'h1);
    tick();
    chk("R12 edge wake ends", {31'd0, wake_req}, '0);
  endtask

  task automatic t_clear_isolation();
    do_reset('0);
    trig_pol = 32'h3; irq_en = 32'h3; pin_lvl = 32'h3;
    tick();
    irq_en = '0; flag_clr = 32'h1; tick(); flag_clr = '0;
    chk("R8 only masked bit cleared", pend_flags, 32'h2);
  endtask

  task automatic t_level_persist();
    do_reset('0);
    trig_pol = 32'h4; irq_en = 32'h4; pin_lvl = 32'h4;
    tick();
    flag_clr = 32'h4; tick(); flag_clr = '0;
    chk("R9 level reasserts", pend_flags, 32'h4);
    pin_lvl = '0; flag_clr = 32'h4; tick(); flag_clr = '0;
    chk("R9 inactive then cleared", pend_flags, '0);
  endtask

  task automatic t_set_wins();
    do_reset('0);
    trig_mode = 32'h10; trig_pol = 32'h10; irq_en = 32'h10;
    tick(); pin_lvl = 32'h10; tick(); pin_lvl = '0; tick();
    pin_lvl = 32'h10; flag_clr = 32'h10; tick(); flag_clr = '0;
    chk("R10 set wins", pend_flags, 32'h10);
    flag_clr = 32'h10; tick(); flag_clr = '0;
    chk("R10 clear alone", pend_flags, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_sample();
    t_level();
    t_edge_single();
    t_dual();
    t_dual_level();
    t_disabled_and_wake();
    t_clear_isolation();
    t_level_persist();
    t_set_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule